// File: doc/BRIEF.md
# Interrupt Request Merger with Edge Capture

This block folds many peripheral interrupt requests into the two external interrupt lines of a small 8-bit microcontroller. Seven active-low request groups (general-purpose I/O, line interface, subscriber interface, power, monitor channel, serial control channel and host) are combined as wired levels. A fixed parameter assigns each group to one of the two output lines. An output line stays low for as long as any request assigned to it is low.

Eight general-purpose pins can also raise interrupts from edges. Pins 0..3 of the first bank feed line 0, and pins 0..3 of the second bank feed line 1. Each pin is synchronized and its selected edge is latched into a sticky flag. The flag holds its line low until software clears it, so edge sources can drive an input that only accepts levels. A three-entry register interface sets the per-pin enable and polarity, reads the flags back, and clears flags by writing ones.

Top module: `irq_merge`

## Requirements
- R1: A group request that is low pulls its assigned output line low in the same cycle, with no register in the path. With the default mapping (`GRP_LINE1` all ones) every group is assigned to `irq1_no`.
- R2: An output line is high only when every group assigned to it is high and every edge flag of its pin bank is clear. It stays low until the last of these sources is removed.
- R3: Group requests never affect the line they are not mapped to. With the default mapping, `irq0_no` ignores every group.
- R4: A selected edge on a pin sets that pin's flag, and drives its line low, on the third rising clock edge after the pin changes. It has no effect after the first or second rising edge.
- R5: Polarity bit 0 captures falling edges and polarity bit 1 captures rising edges. The opposite edge is ignored.
- R6: A pin whose enable bit is 0 never sets its flag, whatever edges it sees.
- R7: Writing address 2 clears every flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R8: If a clear and a new selected edge hit the same flag in the same cycle, the flag ends up set.
- R9: After reset all flags, enables and polarity bits are 0, and both lines are high.
- R10: The register bit layout is bit k = pin k of bank 0 and bit 4+k = pin k of bank 1. Address 0 is the enables, address 1 is the polarity bits, address 2 reads the flags. Reads are combinational, and address 3 reads 0.
- R11: A set flag keeps its line low after the pin returns to its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grp_req_ni | input | 7 | Peripheral request groups, active low |
| pin0_i | input | 4 | Edge pins of bank 0 (line 0) |
| pin1_i | input | 4 | Edge pins of bank 1 (line 1) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq0_no | output | 1 | Interrupt line 0, active low level |
| irq1_no | output | 1 | Interrupt line 1, active low level |

## Verification
The group combine is driven through a vector walk:
- all groups idle;
- single groups low at either end of the vector;
- several groups low at once;
- all groups low.

This separates a true OR of low requests from a single-bit tap, and shows that the unmapped line never moves. Edge capture is exercised directed:
- falling and rising polarity, each against its opposite edge;
- a disabled pin;
- partial clears written with zero bits;
- a clear that coincides with a new edge.

These cases distinguish latch-versus-level behaviour, the synchronizer latency and the set-over-clear priority. A mixed case holds one line low with both a group and a flag, and removes them one at a time.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;
  localparam int unsigned ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_EN   = 2'd0,
    REG_POL  = 2'd1,
    REG_FLAG = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_edge_cell.sv
module irq_edge_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic en_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic flag_o
);
  logic sync1_q, sync2_q, prev_q, flag_q;
  logic rise, fall, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign rise = sync2_q & ~prev_q;
  assign fall = ~sync2_q & prev_q;
  assign hit  = en_i & (pol_i ? rise : fall);

  // a new edge outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= hit | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;

  AST_NO_CAPTURE_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !flag_q) |=> !flag_q);  // R6
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && clr_i) |=> flag_q);  // R8
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);  // R11
  AST_CLEAR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit) |=> !flag_q);  // R7
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_merge_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     flags_i,
  output logic [DW-1:0]     rdata_o,
  output logic [DW-1:0]     en_o,
  output logic [DW-1:0]     pol_o,
  output logic [DW-1:0]     clr_o
);
  logic [DW-1:0] en_q, pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      pol_q <= '0;
    end else if (we_i) begin
      if (addr_i == REG_EN)  en_q  <= wdata_i;
      if (addr_i == REG_POL) pol_q <= wdata_i;
    end
  end

  assign clr_o = (we_i && addr_i == REG_FLAG) ? wdata_i : '0;
  assign en_o  = en_q;
  assign pol_o = pol_q;

  always_comb begin
    unique case (addr_i)
      REG_EN:   rdata_o = en_q;
      REG_POL:  rdata_o = pol_q;
      REG_FLAG: rdata_o = flags_i;
      default:  rdata_o = '0;
    endcase
  end

  AST_EN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == REG_EN) |=> $stable(en_q));  // R10
endmodule

// File: rtl/irq_merge.sv
module irq_merge
  import irq_merge_pkg::*;
#(
  parameter int unsigned             NUM_GRP   = 7,
  parameter int unsigned             PINS      = 4,
  parameter logic [NUM_GRP-1:0]      GRP_LINE1 = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_GRP-1:0]  grp_req_ni,
  input  logic [PINS-1:0]     pin0_i,
  input  logic [PINS-1:0]     pin1_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [2*PINS-1:0]   reg_wdata_i,
  output logic [2*PINS-1:0]   reg_rdata_o,
  output logic                irq0_no,
  output logic                irq1_no
);
  localparam int unsigned NPIN = 2 * PINS;

  logic [NPIN-1:0] pins, en, pol, clr, flags;
  logic            grp_low0, grp_low1;

  assign pins = {pin1_i, pin0_i};

  irq_cfg_regs #(.DW(NPIN)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .flags_i (flags),
    .rdata_o (reg_rdata_o),
    .en_o    (en),
    .pol_o   (pol),
    .clr_o   (clr)
  );

  for (genvar k = 0; k < NPIN; k++) begin : g_cell
    irq_edge_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pins[k]),
      .en_i   (en[k]),
      .pol_i  (pol[k]),
      .clr_i  (clr[k]),
      .flag_o (flags[k])
    );
  end

  assign grp_low0 = |(~grp_req_ni & ~GRP_LINE1);
  assign grp_low1 = |(~grp_req_ni & GRP_LINE1);

  assign irq0_no = ~(grp_low0 | (|flags[PINS-1:0]));
  assign irq1_no = ~(grp_low1 | (|flags[NPIN-1:PINS]));

  AST_LINE0_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flags[PINS-1:0]) |-> !irq0_no);  // R2
  AST_LINE1_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flags[NPIN-1:PINS]) |-> !irq1_no);  // R2
  AST_GROUP_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(~grp_req_ni & GRP_LINE1)) |-> !irq1_no);  // R1
  AST_LINE0_SEPARATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags[PINS-1:0] == '0 && (~grp_req_ni & ~GRP_LINE1) == '0) |-> irq0_no);  // R3
endmodule

// File: tb/irq_merge_test.sv
`timescale 1ns/1ps
module irq_merge_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] grp_req_ni = 7'h7F;
  logic [3:0] pin0_i = 4'hF, pin1_i = 4'hF;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       irq0_no, irq1_no;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  irq_merge uut (.*);

  // {grp_req_ni, expected irq0_no, expected irq1_no}
  localparam logic [8:0] VEC [7] = '{
    {7'h7F, 1'b1, 1'b1},
    {7'h7E, 1'b1, 1'b0},
    {7'h3F, 1'b1, 1'b0},
    {7'h77, 1'b1, 1'b0},
    {7'h55, 1'b1, 1'b0},
    {7'h00, 1'b1, 1'b0},
    {7'h7F, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  function automatic logic [7:0] rd(input logic [1:0] a);
    reg_addr_i = a;
    return reg_rdata_o;
  endfunction

  task automatic read_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    reg_addr_i = a;
    #0.1;
    check(req, reg_rdata_o, exp);
  endtask

  task automatic settle3();
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9: reset state
    check("R9", {6'b0, irq0_no, irq1_no}, 8'h03);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    read_chk("R9", 2'd0, 8'h00);
    read_chk("R9", 2'd1, 8'h00);
    read_chk("R9", 2'd2, 8'h00);
    read_chk("R10", 2'd3, 8'h00);
    check("R9", {6'b0, irq0_no, irq1_no}, 8'h03);

    // R1 R3: group combine vector walk
    for (int i = 0; i < 7; i++) begin
      grp_req_ni = VEC[i][8:2];
      #0.5;
      check("R1/R3", {6'b0, irq0_no, irq1_no}, {6'b0, VEC[i][1:0]});
      @(negedge clk_i);
    end

    // R4 R5 R11: bank0 pin0 falling edge
    wr(2'd0, 8'h01);
    read_chk("R10", 2'd0, 8'h01);
    pin0_i[0] = 1'b0;
    @(negedge clk_i);
    check("R4", {7'b0, irq0_no}, 8'h01);
    @(negedge clk_i);
    check("R4", {7'b0, irq0_no}, 8'h01);
    @(negedge clk_i);
    check("R4", {7'b0, irq0_no}, 8'h00);
    read_chk("R10", 2'd2, 8'h01);
    pin0_i[0] = 1'b1;
    repeat (5) @(negedge clk_i);
    check("R11", {7'b0, irq0_no}, 8'h00);

    // R7: zero bits leave flags, one bits clear
    wr(2'd2, 8'hFE);
    read_chk("R7", 2'd2, 8'h01);
    wr(2'd2, 8'h01);
    read_chk("R7", 2'd2, 8'h00);
    check("R7", {7'b0, irq0_no}, 8'h01);

    // R5: rising polarity ignores falls
    wr(2'd1, 8'h01);
    pin0_i[0] = 1'b0; settle3(); @(negedge clk_i);
    read_chk("R5", 2'd2, 8'h00);
    pin0_i[0] = 1'b1; settle3();
    read_chk("R5", 2'd2, 8'h01);
    wr(2'd2, 8'h01);
    // R5: falling polarity ignores rises
    wr(2'd1, 8'h00);
    pin0_i[0] = 1'b0; settle3();
    wr(2'd2, 8'h01);
    pin0_i[0] = 1'b1; settle3(); @(negedge clk_i);
    read_chk("R5", 2'd2, 8'h00);

    // R6: disabled pin bank1 pin2
    pin1_i[2] = 1'b0; settle3(); @(negedge clk_i);
    pin1_i[2] = 1'b1; settle3(); @(negedge clk_i);
    read_chk("R6", 2'd2, 8'h00);
    check("R6", {7'b0, irq1_no}, 8'h01);

    // R10: bank1 pin2 maps to flag bit 6, drives irq1 only
    wr(2'd0, 8'h40);
    wr(2'd1, 8'h40);
    pin1_i[2] = 1'b0; settle3(); @(negedge clk_i);
    pin1_i[2] = 1'b1; settle3();
    read_chk("R10", 2'd2, 8'h40);
    check("R10", {6'b0, irq0_no, irq1_no}, 8'h02);

    // R2: group and flag both hold irq1 low
    grp_req_ni = 7'h7D;
    #0.5;
    check("R2", {7'b0, irq1_no}, 8'h00);
    grp_req_ni = 7'h7F;
    #0.5;
    check("R2", {7'b0, irq1_no}, 8'h00);
    wr(2'd2, 8'h40);
    check("R2", {7'b0, irq1_no}, 8'h01);

    // R8: clear coinciding with a new edge
    pin1_i[2] = 1'b0; settle3(); @(negedge clk_i);
    pin1_i[2] = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 2'd2; reg_wdata_i = 8'h40;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    read_chk("R8", 2'd2, 8'h40);
    check("R8", {7'b0, irq1_no}, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule